// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the software-visible register front end of a 51-source interrupt controller. A separate detection block turns each source pin into a pending bit. This block reads that pending vector. It holds the per-source enable and routing masks, and it drives two interrupt lines to the processor: a normal line (IRQ) and a fast line (FIQ). Each source is steered to one of the two lines by its select bit. A source reaches its line only when it is both pending and enabled.

Every 51-bit quantity is exposed as two 32-bit bus words. The lower word holds sources 0 to 31. The upper word holds sources 32 to 50 in its bits 0 to 18. Byte-address bit 2 picks the upper word. Enable bits are changed through separate write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. Edge-pending bits are cleared through a write-one-to-clear address. This block does not hold those bits: it sends a one-cycle clear request to the detection block, masked to the sources that are edge-triggered. The trigger configuration (level or edge, both edges, polarity) is also driven out to the detection block. Of that configuration, only four polarity bits of the upper sources can be changed.

The register window starts at byte offset 0x80. The bus is a plain synchronous port. A write takes effect at the clock edge where the write strobe is high. Read data appears on the clock edge after the read strobe and holds until the next read.

Top module: `irqctl_regs`

## Requirements
- R1: After reset, enable, select, pending-clear and both interrupt outputs are zero. Level configuration reads 0x1F07_FFF8FFFF, both-edge configuration reads 0x00F8_00070000, and polarity reads 0x5F07_FFF8FFFF (upper word shown before the underscore, lower word after it).
- R2: Any access whose byte address is below 0x80 is ignored, and a read there returns zero.
- R3: Byte-address bit 2 (relative to 0x80) selects the upper word. Only bits 18:0 of an upper word exist: bits 31:19 are dropped on writes and read as zero.
- R4: Writing offset 0x20 (or 0x24 for the upper word) ORs the ones written into the enable mask. Reading that offset returns the mask.
- R5: Writing offset 0x28 (or 0x2C) clears the enable bits where ones are written. All other enable bits are unchanged.
- R6: Writing the select register at offset 0x18 (lower) or 0x1C (upper) replaces only the addressed half. The other half keeps its value.
- R7: Offset 0x00 reads pending AND enable AND NOT select. Offset 0x08 reads pending AND enable AND select. Offset 0x10 reads the pending vector itself.
- R8: A write to offset 0x58 (or 0x5C) produces, one clock later, a one-cycle clear request equal to the written ones ANDed with NOT level configuration. Level-triggered sources never receive a clear request. With no such write, the request is zero.
- R9: Offset 0x60 (or 0x64) reads pending AND NOT level configuration.
- R10: In the polarity register (offset 0x50 or 0x54), only upper-word bits 18:15 (sources 47 to 50) are writable. Lower-word writes and all other bits are ignored.
- R11: Offsets 0x28, 0x38 and 0x58 read as zero. The level configuration (0x40), both-edge configuration (0x48), status registers and software-trigger register (0x30) ignore writes. Unmapped offsets read zero.
- R12: The FIQ output is the OR of pending AND enable AND select. The IRQ output is the OR of pending AND enable AND NOT select. Both outputs are registered one clock behind their inputs.
- R13: Read data is registered on the clock edge after the read strobe and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 17 | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_pend | input | 51 | Pending vector from the detection block |
| pend_clr | output | 51 | One-cycle clear request for edge-pending bits |
| cfg_level | output | 51 | 1 = level-triggered source, 0 = edge-triggered |
| cfg_both | output | 51 | 1 = edge source fires on both edges |
| cfg_high | output | 51 | 1 = active-high or rising, 0 = active-low or falling |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The routing function is first tried with a single lower-word source: it is pending, enabled and selected, and the select bit is then flipped. This separates a design that routes by select from one that ORs everything onto one line. A second, upper-word source is then added to the other line, so a swapped half or a wrong bit-2 decode shows up as the wrong output. Enable bits are then cleared one at a time, which proves that each line drops only when its own sources go away. Clear writes cover an all-ones word in each half and a word that names only a level source; these separate the edge-only masking from a plain pass-through of the write data.

// File: rtl/irqctl_pkg.sv
// Shared constants and types for the interrupt controller register interface.
// Assumes 51 sources, split as 32 lower-word and 19 upper-word bits.
package irqctl_pkg;

    localparam int NSRC = 51;
    localparam int LO_W = 32;
    localparam int HI_W = NSRC - LO_W;

    typedef logic [NSRC-1:0] srcvec_t;

    // Reset and fixed configuration, written as 64-bit values and trimmed.
    localparam logic [63:0] LEVEL_RST64 = 64'h0000_1F07_FFF8_FFFF;
    localparam logic [63:0] BOTH_RST64  = 64'h0000_00F8_0007_0000;
    localparam logic [63:0] POL_RST64   = 64'h0000_5F07_FFF8_FFFF;
    localparam logic [63:0] POL_WM64    = 64'h0007_8000_0000_0000;

    localparam srcvec_t LEVEL_RST = LEVEL_RST64[NSRC-1:0];
    localparam srcvec_t BOTH_RST  = BOTH_RST64[NSRC-1:0];
    localparam srcvec_t POL_RST   = POL_RST64[NSRC-1:0];
    localparam srcvec_t POL_WMASK = POL_WM64[NSRC-1:0];

    // Register offsets relative to the window base (lower word).
    localparam int OFF_IRQ_ST   = 'h00;
    localparam int OFF_FIQ_ST   = 'h08;
    localparam int OFF_PEND     = 'h10;
    localparam int OFF_SEL      = 'h18;
    localparam int OFF_EN_SET   = 'h20;
    localparam int OFF_EN_CLR   = 'h28;
    localparam int OFF_SW_SET   = 'h30;
    localparam int OFF_SW_CLR   = 'h38;
    localparam int OFF_LEVEL    = 'h40;
    localparam int OFF_BOTH     = 'h48;
    localparam int OFF_POL      = 'h50;
    localparam int OFF_EDGE_CLR = 'h58;
    localparam int OFF_EDGE_ST  = 'h60;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_IRQ_ST,
        RID_FIQ_ST,
        RID_PEND,
        RID_SEL,
        RID_EN_SET,
        RID_EN_CLR,
        RID_SW_SET,
        RID_SW_CLR,
        RID_LEVEL,
        RID_BOTH,
        RID_POL,
        RID_EDGE_CLR,
        RID_EDGE_ST
    } reg_id_t;

endpackage

// File: rtl/irqctl_decode.sv
// Address decoder: maps a byte address to a register id and a word half.
// Assumes the window base is 8-byte aligned; bits 1:0 are ignored.
module irqctl_decode
    import irqctl_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_t           rid,
    output logic              upper
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] off;

    // Split the relative address into the word half and the register offset.
    always_comb begin
        rel   = addr - WIN_BASE;
        upper = rel[2];
        off   = {rel[ADDR_W-1:3], 3'b000};
    end

    // Look up the register id; anything outside the window is none.
    always_comb begin
        rid = RID_NONE;
        if (addr >= WIN_BASE) begin
            case (off)
                ADDR_W'(OFF_IRQ_ST):   rid = RID_IRQ_ST;
                ADDR_W'(OFF_FIQ_ST):   rid = RID_FIQ_ST;
                ADDR_W'(OFF_PEND):     rid = RID_PEND;
                ADDR_W'(OFF_SEL):      rid = RID_SEL;
                ADDR_W'(OFF_EN_SET):   rid = RID_EN_SET;
                ADDR_W'(OFF_EN_CLR):   rid = RID_EN_CLR;
                ADDR_W'(OFF_SW_SET):   rid = RID_SW_SET;
                ADDR_W'(OFF_SW_CLR):   rid = RID_SW_CLR;
                ADDR_W'(OFF_LEVEL):    rid = RID_LEVEL;
                ADDR_W'(OFF_BOTH):     rid = RID_BOTH;
                ADDR_W'(OFF_POL):      rid = RID_POL;
                ADDR_W'(OFF_EDGE_CLR): rid = RID_EDGE_CLR;
                ADDR_W'(OFF_EDGE_ST):  rid = RID_EDGE_ST;
                default:               rid = RID_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irqctl_state.sv
// Writable state: enable mask, select mask, the writable polarity bits,
// and the registered edge-clear request.
// Assumes writes are single-cycle strobes; reset is synchronous active-low.
module irqctl_state
    import irqctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  reg_id_t rid,
    input  logic    upper,
    input  logic [LO_W-1:0] wdata,
    output srcvec_t en_q,
    output srcvec_t sel_q,
    output srcvec_t pol,
    output srcvec_t pend_clr
);

    srcvec_t wvec;

    // Place the write word on its half of the source vector; drop the extra high bits.
    always_comb begin
        if (upper) wvec = {wdata[HI_W-1:0], {LO_W{1'b0}}};
        else       wvec = {{HI_W{1'b0}}, wdata};
    end

    // Enable mask: ones written to the set address set, ones written to the clear address clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= '0;
        else if (wr && rid == RID_EN_SET) en_q <= en_q | wvec;
        else if (wr && rid == RID_EN_CLR) en_q <= en_q & ~wvec;
    end

    // Select mask: replace only the addressed half.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (wr && rid == RID_SEL) begin
            if (upper) sel_q <= {wdata[HI_W-1:0], sel_q[LO_W-1:0]};
            else       sel_q <= {sel_q[NSRC-1:LO_W], wdata};
        end
    end

    // Clear request: a one-cycle pulse, masked to edge-triggered sources.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pend_clr <= '0;
        else if (wr && rid == RID_EDGE_CLR) pend_clr <= wvec & ~LEVEL_RST;
        else                                pend_clr <= '0;
    end

    // Polarity: a flop only where the mask allows a write, a constant elsewhere.
    for (genvar g = 0; g < NSRC; g++) begin : g_pol
        if (POL_WMASK[g]) begin : g_wr
            logic bit_q;
            // Writable polarity bit, loaded only from upper-word writes.
            always_ff @(posedge clk) begin
                if (!rst_n)                              bit_q <= POL_RST[g];
                else if (wr && rid == RID_POL && upper)  bit_q <= wvec[g];
            end
            assign pol[g] = bit_q;
        end else begin : g_fix
            assign pol[g] = POL_RST[g];
        end
    end

endmodule

// File: rtl/irqctl_route.sv
// Routing: combines pending, enable and select into per-line vectors and
// registered IRQ and FIQ outputs. Assumes pending is synchronous to clk.
module irqctl_route
    import irqctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  srcvec_t pend,
    input  srcvec_t en_q,
    input  srcvec_t sel_q,
    output srcvec_t irq_vec,
    output srcvec_t fiq_vec,
    output logic    irq_o,
    output logic    fiq_o
);

    // Per-source active vectors for each line.
    always_comb begin
        fiq_vec = pend & en_q & sel_q;
        irq_vec = pend & en_q & ~sel_q;
    end

    // Register the OR-reduced lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |irq_vec;
            fiq_o <= |fiq_vec;
        end
    end

endmodule

// File: rtl/irqctl_rdmux.sv
// Read path: selects the 51-bit value for a register id, takes the addressed
// half, and registers it on a read strobe. Write-only and unmapped ids read zero.
module irqctl_rdmux
    import irqctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rd,
    input  reg_id_t rid,
    input  logic    upper,
    input  srcvec_t pend,
    input  srcvec_t en_q,
    input  srcvec_t sel_q,
    input  srcvec_t pol,
    input  srcvec_t irq_vec,
    input  srcvec_t fiq_vec,
    output logic [LO_W-1:0] rdata
);

    srcvec_t         val;
    logic [LO_W-1:0] word;

    // Choose the full-width register value.
    always_comb begin
        case (rid)
            RID_IRQ_ST:  val = irq_vec;
            RID_FIQ_ST:  val = fiq_vec;
            RID_PEND:    val = pend;
            RID_SEL:     val = sel_q;
            RID_EN_SET:  val = en_q;
            RID_LEVEL:   val = LEVEL_RST;
            RID_BOTH:    val = BOTH_RST;
            RID_POL:     val = pol;
            RID_EDGE_ST: val = pend & ~LEVEL_RST;
            default:     val = '0;
        endcase
    end

    // Take the addressed half, zero-extending the upper word.
    always_comb begin
        if (upper) word = {{(LO_W-HI_W){1'b0}}, val[NSRC-1:LO_W]};
        else       word = val[LO_W-1:0];
    end

    // Load the read data on a strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= word;
    end

endmodule

// File: rtl/irqctl_regs.sv
// Top of the interrupt controller register interface. It decodes the bus,
// holds the enable and select masks, routes pending sources to IRQ or FIQ,
// and drives the trigger configuration and edge-clear requests to the
// detection block. Assumes a single synchronous bus port and an active-low
// synchronous reset.
module irqctl_regs
    import irqctl_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [LO_W-1:0]   bus_wdata,
    output logic [LO_W-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_pend,
    output logic [NSRC-1:0]   pend_clr,
    output logic [NSRC-1:0]   cfg_level,
    output logic [NSRC-1:0]   cfg_both,
    output logic [NSRC-1:0]   cfg_high,
    output logic              irq_o,
    output logic              fiq_o
);

    reg_id_t rid;
    logic    upper;
    srcvec_t en_q;
    srcvec_t sel_q;
    srcvec_t pol;
    srcvec_t irq_vec;
    srcvec_t fiq_vec;

    irqctl_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
        .addr  (bus_addr),
        .rid   (rid),
        .upper (upper)
    );

    irqctl_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rid      (rid),
        .upper    (upper),
        .wdata    (bus_wdata),
        .en_q     (en_q),
        .sel_q    (sel_q),
        .pol      (pol),
        .pend_clr (pend_clr)
    );

    irqctl_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (src_pend),
        .en_q    (en_q),
        .sel_q   (sel_q),
        .irq_vec (irq_vec),
        .fiq_vec (fiq_vec),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o)
    );

    irqctl_rdmux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .rid     (rid),
        .upper   (upper),
        .pend    (src_pend),
        .en_q    (en_q),
        .sel_q   (sel_q),
        .pol     (pol),
        .irq_vec (irq_vec),
        .fiq_vec (fiq_vec),
        .rdata   (bus_rdata)
    );

    // Configuration driven to the detection block.
    assign cfg_level = LEVEL_RST;
    assign cfg_both  = BOTH_RST;
    assign cfg_high  = pol;

endmodule

// File: rtl/irqctl_regs_chk.sv
// Property checker for irqctl_regs, attached by bind. It observes the ports
// and the enable and select masks.
module irqctl_regs_chk
    import irqctl_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [LO_W-1:0]   bus_rdata,
    input logic [NSRC-1:0]   src_pend,
    input logic [NSRC-1:0]   pend_clr,
    input logic [NSRC-1:0]   cfg_level,
    input logic [NSRC-1:0]   cfg_both,
    input logic [NSRC-1:0]   cfg_high,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   sel_q,
    input logic              irq_o,
    input logic              fiq_o
);

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic              hit_clr;

    // Decode, independently of the design, the facts the properties need.
    always_comb begin
        rel     = bus_addr - WIN_BASE;
        in_win  = bus_addr >= WIN_BASE;
        hit_clr = bus_wr && in_win && ((rel & ~ADDR_W'(7)) == ADDR_W'(OFF_EDGE_CLR));
    end

    p_fiq_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|(src_pend & en_q & sel_q))));
    p_irq_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(src_pend & en_q & ~sel_q))));
    p_clr_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr & cfg_level) == '0);
    p_clr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr == 1'b0 |=> pend_clr == '0);
    p_cfg_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(cfg_level) && $stable(cfg_both)));
    p_pol_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg_high & ~POL_WMASK));
    p_below_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_win) |=> bus_rdata == '0);
    p_hi_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_win && rel[2]) |=> bus_rdata[LO_W-1:HI_W] == '0);
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind irqctl_regs irqctl_regs_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .src_pend  (src_pend),
    .pend_clr  (pend_clr),
    .cfg_level (cfg_level),
    .cfg_both  (cfg_both),
    .cfg_high  (cfg_high),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/irqctl_regs_test.sv
// Scoreboard bench: the read driver queues expected words, and a monitor pops
// and compares them when read data comes back.
module irqctl_regs_test;
    import irqctl_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [16:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src_pend = '0;
    logic [NSRC-1:0] pend_clr;
    logic [NSRC-1:0] cfg_level;
    logic [NSRC-1:0] cfg_both;
    logic [NSRC-1:0] cfg_high;
    logic            irq_o;
    logic            fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rd_d = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [16:0] addr;
        string       tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #2 clk = ~clk;

    irqctl_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_pend  (src_pend),
        .pend_clr  (pend_clr),
        .cfg_level (cfg_level),
        .cfg_both  (cfg_both),
        .cfg_high  (cfg_high),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [16:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp  = e;
        it.addr = a;
        it.tag  = tag;
        sb.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    // Note that a read was issued in the previous cycle.
    always @(posedge clk) rd_d <= bus_rd;

    // Monitor: compare returned read data against the queued expectation.
    always @(negedge clk) begin
        if (rd_d) begin
            if (sb.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R13: read data with no expectation, actual 0x%0h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                check($sformatf("%s @0x%0h", it.tag, it.addr), {32'h0, bus_rdata}, {32'h0, it.exp});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 irq reset", {63'h0, irq_o}, 64'h0);
        check("R1 fiq reset", {63'h0, fiq_o}, 64'h0);
        check("R1 clr reset", {13'h0, pend_clr}, 64'h0);
        check("R1 level cfg", {13'h0, cfg_level}, 64'h1F07_FFF8_FFFF);
        check("R1 both cfg", {13'h0, cfg_both}, 64'h00F8_0007_0000);
        rst_n = 1'b1;

        // R1: register reset values
        rd(17'hC0, 32'hFFF8_FFFF, "R1 level lo");
        rd(17'hC4, 32'h0000_1F07, "R1 level hi");
        rd(17'hC8, 32'h0007_0000, "R1 both lo");
        rd(17'hCC, 32'h0000_00F8, "R1 both hi");
        rd(17'hD0, 32'hFFF8_FFFF, "R1 pol lo");
        rd(17'hD4, 32'h0000_5F07, "R1 pol hi");
        rd(17'hA0, 32'h0, "R1 enable");
        rd(17'h98, 32'h0, "R1 select");

        // R2: below the window
        wr(17'h20, 32'hFFFF_FFFF);
        wr(17'h18, 32'hFFFF_FFFF);
        rd(17'hA0, 32'h0, "R2 enable untouched");
        rd(17'h98, 32'h0, "R2 select untouched");
        rd(17'h20, 32'h0, "R2 low read");

        // R3: upper word is 19 bits
        wr(17'hA4, 32'hFFFF_FFFF);
        rd(17'hA4, 32'h0007_FFFF, "R3 upper masked");
        rd(17'hA0, 32'h0, "R3 lower untouched");
        wr(17'hAC, 32'hFFFF_FFFF);
        rd(17'hA4, 32'h0, "R3 upper cleared");

        // R4 / R5: set and clear enable
        wr(17'hA0, 32'h1);
        wr(17'hA0, 32'h4);
        rd(17'hA0, 32'h5, "R4 enable OR");
        wr(17'hA8, 32'h1);
        rd(17'hA0, 32'h4, "R5 enable clear");

        // R6: select halves
        wr(17'h98, 32'hF0);
        wr(17'h9C, 32'h3);
        rd(17'h98, 32'hF0, "R6 lower kept");
        rd(17'h9C, 32'h3, "R6 upper");
        wr(17'h98, 32'h0F);
        rd(17'h9C, 32'h3, "R6 upper kept");
        rd(17'h98, 32'h0F, "R6 lower replaced");

        // R12 / R7: lower source 2, enabled and selected to FIQ
        @(negedge clk);
        src_pend = 51'h4;
        repeat (2) @(negedge clk);
        check("R12 fiq on", {63'h0, fiq_o}, 64'h1);
        check("R12 irq off", {63'h0, irq_o}, 64'h0);
        rd(17'h88, 32'h4, "R7 fiq status");
        rd(17'h80, 32'h0, "R7 irq status");
        rd(17'h90, 32'h4, "R7 pending");
        wr(17'h98, 32'h0);
        @(negedge clk);
        check("R12 irq after reselect", {63'h0, irq_o}, 64'h1);
        check("R12 fiq after reselect", {63'h0, fiq_o}, 64'h0);
        rd(17'h80, 32'h4, "R7 irq status");
        rd(17'h88, 32'h0, "R7 fiq status");

        // R12: upper source 40 on FIQ alongside source 2 on IRQ
        wr(17'hA4, 32'h100);
        wr(17'h9C, 32'h100);
        @(negedge clk);
        src_pend = 51'h100_0000_0004;
        repeat (2) @(negedge clk);
        check("R12 both lines irq", {63'h0, irq_o}, 64'h1);
        check("R12 both lines fiq", {63'h0, fiq_o}, 64'h1);
        rd(17'h8C, 32'h100, "R7 fiq status hi");
        wr(17'hA8, 32'h4);
        @(negedge clk);
        check("R12 irq dropped", {63'h0, irq_o}, 64'h0);
        check("R12 fiq kept", {63'h0, fiq_o}, 64'h1);
        wr(17'hAC, 32'h100);
        @(negedge clk);
        check("R12 fiq dropped", {63'h0, fiq_o}, 64'h0);

        // R9: edge status masks out level sources
        @(negedge clk);
        src_pend = 51'h2000_0001_0001;
        @(negedge clk);
        rd(17'hE0, 32'h0001_0000, "R9 edge lo");
        rd(17'hE4, 32'h0000_2000, "R9 edge hi");
        rd(17'h90, 32'h0001_0001, "R9 pending lo");
        rd(17'h94, 32'h0000_2000, "R9 pending hi");

        // R8: clear requests
        wr(17'hD8, 32'hFFFF_FFFF);
        check("R8 clr lo", {13'h0, pend_clr}, 64'h0000_0007_0000);
        @(negedge clk);
        check("R8 clr pulse ends", {13'h0, pend_clr}, 64'h0);
        wr(17'hDC, 32'hFFFF_FFFF);
        check("R8 clr hi", {13'h0, pend_clr}, 64'h7_E0F8_0000_0000);
        wr(17'hD8, 32'h1);
        check("R8 clr level src", {13'h0, pend_clr}, 64'h0);

        // R10: polarity write mask
        wr(17'hD0, 32'h0);
        rd(17'hD0, 32'hFFF8_FFFF, "R10 pol lo ignored");
        wr(17'hD4, 32'hFFFF_FFFF);
        rd(17'hD4, 32'h0007_DF07, "R10 pol hi set");
        check("R10 cfg_high top", {60'h0, cfg_high[50:47]}, 64'hF);
        wr(17'hD4, 32'h0);
        rd(17'hD4, 32'h0000_5F07, "R10 pol hi cleared");

        // R11: write-only, read-only, unmapped
        rd(17'hA8, 32'h0, "R11 enable clear reads 0");
        rd(17'hB8, 32'h0, "R11 sw clear reads 0");
        rd(17'hD8, 32'h0, "R11 edge clear reads 0");
        wr(17'hC0, 32'h0);
        rd(17'hC0, 32'hFFF8_FFFF, "R11 level ignores write");
        wr(17'hC8, 32'hFFFF_FFFF);
        rd(17'hC8, 32'h0007_0000, "R11 both ignores write");
        wr(17'hB0, 32'h1);
        rd(17'hB0, 32'h0, "R11 sw trigger");
        rd(17'hE8, 32'h0, "R11 unmapped");
        rd(17'h1000, 32'h0, "R11 far unmapped");

        // R13: read data holds with no strobe
        rd(17'hC4, 32'h0000_1F07, "R13 read");
        repeat (3) @(negedge clk);
        check("R13 hold", {32'h0, bus_rdata}, 64'h1F07);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule